// File: doc/BRIEF.md
# Serial Sync Word Correlator

This block finds a synchronization word in a serial bit stream so that the logic downstream can mark where a message starts. Each accepted bit moves into a window register as wide as the sync word. Every clock the window is compared bit by bit with a programmable reference word. The number of positions that differ is the mismatch score, and the block also reports it as a signed correlation value.

A sync pulse marks the best alignment, not the first alignment that is good enough. A window becomes a candidate when its mismatch score is at or below a programmable error allowance and no worse than the window before it. The pulse is raised when the next accepted bit makes the score worse. An allowance of zero turns the block into an exact-match detector. A search-enable input stops reporting while the payload of a message passes, so that look-alike words in the data are not flagged. Whenever the search restarts, the window must fill again before the block can report anything.

Top module: `sync_correlator`

## Requirements
- R1: When `bit_vld` is high at a clock edge, `bit_in` enters window bit 0 and every older bit moves one place up. Without `bit_vld` the window holds its contents.
- R2: `miss_cnt` is the number of positions i where window bit i differs from bit i of the registered reference. Window bit 0 is the newest bit, so a word sent MSB first lines up with the reference.
- R3: `corr_val` is the signed value PAT_W minus twice `miss_cnt`. This is the sum of the window bits, each weighted +1 where it agrees with the reference and -1 where it differs.
- R4: `ref_word` and `max_err` are sampled on every clock edge. A change reaches `miss_cnt` one clock after it is applied, even if no bit is accepted.
- R5: A window is a candidate when all of the following hold at the edge that accepts its last bit: search is enabled, the window is full, its score is at or below the registered allowance, and its score is no worse than the window before it. The first full window needs no comparison with an earlier window.
- R6: `sync_pulse` goes high for one cycle after the edge that accepts the bit following a candidate, but only when the new score is strictly worse than the candidate's score. Two pulses are never back to back.
- R7: When `max_err` is 0, only a window equal to the reference can produce a pulse.
- R8: After reset, and after every time search is re-enabled, no pulse can occur until PAT_W bits have been accepted with search enabled.
- R9: While `search_en` is low, `sync_pulse` stays low, the fill count clears and any pending candidate is dropped.
- R10: Reset clears the window, the registered reference, the allowance and the pulse, so `miss_cnt` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this clock |
| ref_word | input | PAT_W | Sync word to search for, oldest bit in the MSB |
| max_err | input | CW | Maximum number of bit errors allowed |
| search_en | input | 1 | Enables reporting of sync words |
| sync_pulse | output | 1 | One-cycle mark of the correlation peak |
| miss_cnt | output | CW | Mismatch count of the current window |
| corr_val | output | CW+1 | Signed correlation of the current window |

## Verification
The bench drives the 0x61 word with no errors and with a single flipped bit, under allowances of zero and one. A design that fires on the first passing window, or on a window inside the threshold that is not the best one, would count the wrong number of pulses in these runs. The bench also enables search partway through a sync word. A fill counter that ignores the restart would then report a word that was only partly seen, and a design that ignores `search_en` would pulse during the disabled run. Random streams include stalls on `bit_vld` and reference changes between bits. These would expose a window that shifts on invalid cycles, a reference applied without its register stage, or a peak decision that compares the wrong pair of scores.

// File: rtl/cor_pkg.sv
package cor_pkg;
   // Width needed to hold a count from 0 to w inclusive
   function automatic int count_width(input int w);
      return $clog2(w + 1);
   endfunction

   // Above this window width the mismatch counter is built from two halves
   localparam int SPLIT_LIMIT = 8;
endpackage

// File: rtl/cor_window.sv
module cor_window #(
   parameter int PAT_W = 8,
   localparam int FW = cor_pkg::count_width(PAT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_in,
   input  logic             bit_vld,
   input  logic             search_en,
   output logic [PAT_W-1:0] win_q,
   output logic [PAT_W-1:0] win_nxt,
   output logic             full_q,
   output logic             full_nxt
);
   logic [FW-1:0] fill_q;

   // Window contents after this edge; newest bit lands in bit 0
   always_comb begin
      win_nxt = win_q;
      if (bit_vld) win_nxt = {win_q[PAT_W-2:0], bit_in};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q <= '0;
      else        win_q <= win_nxt;
   end

   // The fill count restarts whenever search is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   fill_q <= '0;
      else if (!search_en)                          fill_q <= '0;
      else if (bit_vld && fill_q != FW'(PAT_W))     fill_q <= fill_q + 1'b1;
   end

   assign full_q   = (fill_q == FW'(PAT_W));
   assign full_nxt = search_en && bit_vld && (fill_q >= FW'(PAT_W - 1));

   AST_WIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_vld |=> $stable(win_q)); // R1
endmodule

// File: rtl/cor_mismatch.sv
module cor_mismatch #(
   parameter int PAT_W = 8,
   localparam int CW = cor_pkg::count_width(PAT_W)
) (
   input  logic [PAT_W-1:0] word_a,
   input  logic [PAT_W-1:0] word_b,
   output logic [CW-1:0]    count
);
   logic [PAT_W-1:0] diff;
   assign diff = word_a ^ word_b;

   if (PAT_W <= cor_pkg::SPLIT_LIMIT) begin : g_flat
      always_comb begin
         count = '0;
         for (int i = 0; i < PAT_W; i++) count = count + CW'(diff[i]);
      end
   end else begin : g_halves
      localparam int LO_W = PAT_W / 2;
      localparam int HI_W = PAT_W - LO_W;
      logic [CW-1:0] cnt_lo, cnt_hi;
      always_comb begin
         cnt_lo = '0;
         for (int i = 0; i < LO_W; i++) cnt_lo = cnt_lo + CW'(diff[i]);
      end
      always_comb begin
         cnt_hi = '0;
         for (int i = 0; i < HI_W; i++) cnt_hi = cnt_hi + CW'(diff[LO_W+i]);
      end
      assign count = cnt_lo + cnt_hi;
   end
endmodule

// File: rtl/cor_peak.sv
module cor_peak #(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          search_en,
   input  logic          bit_vld,
   input  logic          full_q,
   input  logic          full_nxt,
   input  logic [CW-1:0] score_cur,
   input  logic [CW-1:0] score_nxt,
   input  logic [CW-1:0] thr_q,
   output logic          sync_q
);
   logic cand_q;
   logic cand_d;
   logic peak_d;

   // The window entering now is no worse than the one it replaces
   assign cand_d = full_nxt && (score_nxt <= thr_q) &&
                   (!full_q || (score_nxt <= score_cur));
   // The previous candidate is confirmed as a peak when the score gets worse
   assign peak_d = cand_q && (score_nxt > score_cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cand_q <= 1'b0;
         sync_q <= 1'b0;
      end else if (!search_en) begin
         cand_q <= 1'b0;
         sync_q <= 1'b0;
      end else if (bit_vld) begin
         cand_q <= cand_d;
         sync_q <= peak_d;
      end else begin
         sync_q <= 1'b0;
      end
   end

   AST_PULSE_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> $past(bit_vld)); // R6
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |=> !sync_q); // R6
   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      sync_q |-> $past(search_en)); // R9
endmodule

// File: rtl/sync_correlator.sv
module sync_correlator #(
   parameter int PAT_W = 8,
   localparam int CW = cor_pkg::count_width(PAT_W)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bit_in,
   input  logic                 bit_vld,
   input  logic [PAT_W-1:0]     ref_word,
   input  logic [CW-1:0]        max_err,
   input  logic                 search_en,
   output logic                 sync_pulse,
   output logic [CW-1:0]        miss_cnt,
   output logic signed [CW:0]   corr_val
);
   if (PAT_W < 2 || PAT_W > 64) begin : g_bad_width
      $error("sync_correlator: PAT_W must lie between 2 and 64");
   end

   logic [PAT_W-1:0] ref_q;
   logic [CW-1:0]    thr_q;
   logic [PAT_W-1:0] win_q, win_nxt;
   logic             full_q, full_nxt;
   logic [CW-1:0]    score_cur, score_nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
         thr_q <= '0;
      end else begin
         ref_q <= ref_word;
         thr_q <= max_err;
      end
   end

   cor_window #(.PAT_W(PAT_W)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .search_en(search_en), .win_q(win_q), .win_nxt(win_nxt),
      .full_q(full_q), .full_nxt(full_nxt));

   cor_mismatch #(.PAT_W(PAT_W)) u_cnt_cur (
      .word_a(win_q), .word_b(ref_q), .count(score_cur));

   cor_mismatch #(.PAT_W(PAT_W)) u_cnt_nxt (
      .word_a(win_nxt), .word_b(ref_q), .count(score_nxt));

   cor_peak #(.CW(CW)) u_peak (
      .clk(clk), .rst_n(rst_n), .search_en(search_en), .bit_vld(bit_vld),
      .full_q(full_q), .full_nxt(full_nxt), .score_cur(score_cur),
      .score_nxt(score_nxt), .thr_q(thr_q), .sync_q(sync_pulse));

   localparam logic [CW:0] FULL_SCALE = (CW+1)'(PAT_W);

   assign miss_cnt = score_cur;
   assign corr_val = $signed(FULL_SCALE - {score_cur, 1'b0});

   AST_SCORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      miss_cnt <= CW'(PAT_W)); // R2
   AST_PULSE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> $past(full_q)); // R8
   AST_EXACT_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_pulse && $past(thr_q) == '0) |-> $past(score_cur) == '0); // R7
endmodule

// File: tb/sim_sync_correlator.sv
`timescale 1ns/1ps
module sim_sync_correlator;
   localparam int W  = 8;
   localparam int CW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_in = 1'b0, bit_vld = 1'b0, search_en = 1'b0;
   logic [W-1:0] ref_word = '0;
   logic [CW-1:0] max_err = '0;
   logic sync_pulse;
   logic [CW-1:0] miss_cnt;
   logic signed [CW:0] corr_val;

   sync_correlator #(.PAT_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
      .ref_word(ref_word), .max_err(max_err), .search_en(search_en),
      .sync_pulse(sync_pulse), .miss_cnt(miss_cnt), .corr_val(corr_val));

   always #2 clk = ~clk;

   int nchk = 0, nerr = 0, pulses = 0;
   bit finished = 0;
   logic [W-1:0] m_win = '0, m_ref = '0;
   int m_thr = 0, m_fill = 0;
   bit m_cand = 0, m_sync = 0;

   function automatic int pop(input logic [W-1:0] x);
      int c = 0;
      for (int i = 0; i < W; i++) c += int'(x[i]);
      return c;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // One clock: drive at the falling edge, update the model at the rising edge, compare after it
   task automatic step(input bit b, input bit v, input bit se,
                       input logic [W-1:0] rw, input int th);
      logic [W-1:0] nwin;
      int s_cur, s_nxt;
      bit full_now, full_next;
      @(negedge clk);
      bit_in = b; bit_vld = v; search_en = se; ref_word = rw; max_err = CW'(th);
      @(posedge clk);
      nwin  = v ? {m_win[W-2:0], b} : m_win;
      s_cur = pop(m_win ^ m_ref);
      s_nxt = pop(nwin ^ m_ref);
      if (!se) begin
         m_fill = 0; m_cand = 0; m_sync = 0;
      end else if (v) begin
         full_now  = (m_fill == W);
         full_next = (m_fill >= W - 1);
         m_sync = m_cand && (s_nxt > s_cur);
         m_cand = full_next && (s_nxt <= m_thr) && (!full_now || s_nxt <= s_cur);
         if (m_fill < W) m_fill++;
      end else begin
         m_sync = 0;
      end
      m_win = nwin; m_ref = rw; m_thr = th;
      #1;
      chk("R1/R2/R4 mismatch score", int'(miss_cnt), pop(m_win ^ m_ref));
      chk("R3 correlation value", int'(corr_val), W - 2 * pop(m_win ^ m_ref));
      chk("R5/R6/R8/R9 sync pulse", int'(sync_pulse), int'(m_sync));
      if (sync_pulse) pulses++;
   endtask

   task automatic send_word(input logic [W-1:0] w, input bit se,
                            input logic [W-1:0] rw, input int th);
      for (int i = W - 1; i >= 0; i--) step(w[i], 1'b1, se, rw, th);
   endtask

   initial begin
      #(4 * 150000);
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10 reset sync", int'(sync_pulse), 0);
      chk("R10 reset score", int'(miss_cnt), 0);
      @(negedge clk); rst_n = 1'b1;

      // R4: reference change with no bit accepted shows up one clock later
      step(1'b0, 1'b0, 1'b0, 8'hF0, 0);
      chk("R4 registered reference", int'(miss_cnt), 4);

      // R7: exact word 0x61 with no error allowed, then a one-bit-off word
      pulses = 0;
      send_word(8'h00, 1'b1, 8'h61, 0);
      send_word(8'h61, 1'b1, 8'h61, 0);
      step(1'b0, 1'b1, 1'b1, 8'h61, 0);
      chk("R7 exact word gives one pulse", int'(sync_pulse), 1);
      send_word(8'h60, 1'b1, 8'h61, 0);
      step(1'b0, 1'b1, 1'b1, 8'h61, 0);
      chk("R7 one error rejected in exact mode", pulses, 1);

      // R5: one error allowed, the same one-bit-off word is a peak
      pulses = 0;
      send_word(8'h00, 1'b1, 8'h61, 1);
      send_word(8'h60, 1'b1, 8'h61, 1);
      step(1'b0, 1'b1, 1'b1, 8'h61, 1);
      chk("R5 tolerant peak", pulses, 1);

      // R9: search disabled, the exact word passes unreported
      pulses = 0;
      send_word(8'h00, 1'b0, 8'h61, 0);
      send_word(8'h61, 1'b0, 8'h61, 0);
      step(1'b0, 1'b1, 1'b0, 8'h61, 0);
      chk("R9 no pulse while disabled", pulses, 0);

      // R8: search enabled one bit into the word, window not full in time
      pulses = 0;
      send_word(8'h00, 1'b0, 8'h61, 0);
      step(1'b0, 1'b1, 1'b0, 8'h61, 0);
      for (int i = W - 2; i >= 0; i--) step(8'h61 >> i, 1'b1, 1'b1, 8'h61, 0);
      step(1'b0, 1'b1, 1'b1, 8'h61, 0);
      chk("R8 partial fill not reported", pulses, 0);
      send_word(8'h61, 1'b1, 8'h61, 0);
      step(1'b0, 1'b1, 1'b1, 8'h61, 0);
      chk("R8 reported once filled", pulses, 1);

      // Random streams with stalls, embedded words and changing settings
      begin
         logic [W-1:0] rw;
         int th;
         bit se;
         void'($urandom(32'd4711));
         rw = W'($urandom); th = 1; se = 1;
         for (int n = 0; n < 3000; n++) begin
            if (($urandom % 200) == 0) rw = W'($urandom);
            if (($urandom % 150) == 0) th = int'($urandom % 4);
            if (($urandom % 100) == 0) se = ~se;
            if (($urandom % 40) == 0)
               send_word(rw ^ (W'(1) << ($urandom % W)) & {W{($urandom % 2) == 1}} | rw & ~{W{1'b0}}, se, rw, th);
            else
               step(1'($urandom), (($urandom % 5) != 0), se, rw, th);
         end
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule